// File: doc/BRIEF.md
# Interrupt Status-Word Swap Unit

This block holds one CPU's 128-bit program status word (PSW) and performs the interrupt swap for six interrupt classes: restart, external, supervisor call, program check, machine check and I/O. When a class is granted, the block writes the current PSW to a save area for that class. It then reads the replacement PSW from a fixed slot in low memory. The new word becomes visible in one step at the end of the swap. All of this traffic uses a simple request/acknowledge memory port, and every address is relocated through a per-CPU prefix register.

The execution side can load a whole PSW or switch the PSW to 64-bit addressing. It can also write and read the prefix register, and it can translate any logical address through the same prefix relocation. I/O and external requests are gated by their mask bits. A PSW with the wait bit set and both masks clear freezes the unit until reset. Architectural bit n of the PSW is `psw_o[127-n]`. The control word (bits 0–63) is `psw_o[127:64]` and the instruction address is `psw_o[63:0]`.

Top module: `psw_swap_unit`

## Requirements
- R1: After reset, `psw_o` is zero, `pfx_o` is zero, and `busy_o` and `halted_o` are low.
- R2: When the unit is idle, not halted and no request is granted, `psw_ld_i` replaces all 128 bits of `psw_o` at the next clock edge.
- R3: Requests are indexed on `irq_req_i` as 0 restart, 1 external, 2 SVC, 3 program, 4 machine check and 5 I/O. When several eligible requests are present, the priority is machine check, program, SVC, external, I/O, restart.
- R4: An I/O request is eligible only when architectural bit 6 (`psw_o[121]`) is 1. An external request is eligible only when bit 7 (`psw_o[120]`) is 1. The other classes cannot be masked.
- R5: A swap performs two writes and then two reads, all of 64 bits:
  - It writes the control word to the save slot 0x300+16*class and the instruction address to that slot+8.
  - It then reads the new control word from the class's new slot and the new address from slot+8.
  - The new slots are restart 0x068, external 0x1C0, SVC 0x1C8, program 0x1D0, machine check 0x1D8 and I/O 0x1E0.
- R6: `psw_o` does not change while `busy_o` is high. It takes the complete fetched word at the edge that ends the swap.
- R7: Each memory transfer holds `mem_req_o` until `mem_ack_i`. With a responder that acknowledges in the cycle after a request, `busy_o` stays high for exactly 8 cycles.
- R8: A prefix write (`pfx_we_i`) shows on `pfx_o` after the next clock edge. The prefix is a page number, that is, address bits 63:12.
- R9: Relocation applies to both the swap accesses and the `xl_log_i`→`xl_phys_o` path:
  - A logical address in page 0 maps to the prefix page.
  - An address in the prefix page maps to page 0.
  - Any other address is unchanged.
- R10: `amode64_set_i` sets bit 31 (`psw_o[96]`) to 1 and bit 32 (`psw_o[95]`) to 0, and leaves every other bit unchanged.
- R11: When wait bit 2 (`psw_o[125]`) is 1 and bits 6 and 7 are 0, `halted_o` is high.
  - In that state no request is granted, and PSW loads and mode sets are ignored.
  - Only reset leaves the state.
- R12: `irq_ack_o` is one-hot or zero. It marks the granted class in the idle cycle in which the swap starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 6 | Interrupt request per class, held until acknowledged |
| irq_ack_o | output | 6 | One-hot grant in the cycle the swap starts |
| psw_ld_i | input | 1 | Load a whole PSW |
| psw_ld_data_i | input | 128 | PSW value to load |
| amode64_set_i | input | 1 | Select 64-bit addressing in the PSW |
| pfx_we_i | input | 1 | Write the prefix register |
| pfx_data_i | input | ADDR_W-12 | New prefix page number |
| pfx_o | output | ADDR_W-12 | Prefix register read-back |
| xl_log_i | input | ADDR_W | Logical address to relocate |
| xl_phys_o | output | ADDR_W | Relocated physical address |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | ADDR_W | Physical byte address of the 64-bit word |
| mem_wdata_o | output | 64 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle per transfer |
| mem_rdata_i | input | 64 | Read data, valid with the acknowledge |
| psw_o | output | 128 | Current PSW |
| busy_o | output | 1 | Swap in progress |
| halted_o | output | 1 | Disabled-wait halt |

## Verification
The assertions assume the following about the inputs:
- A requester holds its line until it sees the acknowledge.
- The memory gives at most one `mem_ack_i` per request and returns read data in that same cycle.
- The prefix is not rewritten during a swap.

The bench meets these assumptions as follows. Its memory model acknowledges exactly once, one cycle after it sees a request. Requests are dropped right after the grant edge. The prefix is written only while the unit is idle.

// File: rtl/psw_swap_pkg.sv
package psw_swap_pkg;
  localparam int unsigned N_CLASS = 6;
  localparam int unsigned PSW_W   = 128;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned OFF_W   = 12;

  typedef enum logic [2:0] {
    CL_RESTART = 3'd0,
    CL_EXT     = 3'd1,
    CL_SVC     = 3'd2,
    CL_PROG    = 3'd3,
    CL_MCHK    = 3'd4,
    CL_IO      = 3'd5
  } irq_class_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ST_HI, SQ_ST_LO, SQ_LD_HI, SQ_LD_LO
  } seq_state_e;

  // architectural bit n lives at psw[127-n]
  localparam int unsigned B_WAIT    = 127 - 2;
  localparam int unsigned B_IO_MSK  = 127 - 6;
  localparam int unsigned B_EXT_MSK = 127 - 7;
  localparam int unsigned B_EA      = 127 - 31;
  localparam int unsigned B_BA      = 127 - 32;

  function automatic logic [OFF_W-1:0] new_slot(irq_class_e c);
    case (c)
      CL_RESTART: return 12'h068;
      CL_EXT:     return 12'h1C0;
      CL_SVC:     return 12'h1C8;
      CL_PROG:    return 12'h1D0;
      CL_MCHK:    return 12'h1D8;
      CL_IO:      return 12'h1E0;
      default:    return 12'h000;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] old_slot(irq_class_e c);
    return 12'h300 + {5'd0, c, 4'd0};
  endfunction
endpackage

// File: rtl/psw_irq_arb.sv
module psw_irq_arb
  import psw_swap_pkg::*;
(
  input  logic [N_CLASS-1:0] req_i,
  input  logic               enable_i,
  input  logic               io_en_i,
  input  logic               ext_en_i,
  output logic [N_CLASS-1:0] grant_o,
  output logic               any_o,
  output irq_class_e         cls_o
);
  // highest priority in the low field
  localparam logic [3*N_CLASS-1:0] PRIO_LIST =
    {CL_RESTART, CL_IO, CL_EXT, CL_SVC, CL_PROG, CL_MCHK};

  logic [N_CLASS-1:0] eligible;
  logic [2:0]         idx;

  always_comb begin
    eligible         = req_i;
    eligible[CL_IO]  = req_i[CL_IO] & io_en_i;
    eligible[CL_EXT] = req_i[CL_EXT] & ext_en_i;
    grant_o = '0;
    cls_o   = CL_RESTART;
    idx     = '0;
    for (int i = N_CLASS - 1; i >= 0; i--) begin
      idx = PRIO_LIST[3*i +: 3];
      if (eligible[idx]) begin
        grant_o      = '0;
        grant_o[idx] = 1'b1;
        cls_o        = irq_class_e'(idx);
      end
    end
    if (!enable_i) grant_o = '0;
    any_o = |grant_o;
  end
endmodule

// File: rtl/psw_prefix_xlate.sv
module psw_prefix_xlate
  import psw_swap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  localparam int unsigned PFX_W = ADDR_W - OFF_W
) (
  input  logic [PFX_W-1:0]  pfx_i,
  input  logic [ADDR_W-1:0] log_i,
  output logic [ADDR_W-1:0] phys_o
);
  logic [PFX_W-1:0] page;
  assign page = log_i[ADDR_W-1:OFF_W];

  always_comb begin
    if (page == '0)        phys_o = {pfx_i, log_i[OFF_W-1:0]};
    else if (page == pfx_i) phys_o = {{PFX_W{1'b0}}, log_i[OFF_W-1:0]};
    else                   phys_o = log_i;
  end
endmodule

// File: rtl/psw_swap_seq.sv
module psw_swap_seq
  import psw_swap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  localparam int unsigned PFX_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  irq_class_e        cls_i,
  input  logic [PSW_W-1:0]  psw_i,
  input  logic [PFX_W-1:0]  pfx_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic [PSW_W-1:0]  new_psw_o
);
  seq_state_e        state_q;
  irq_class_e        cls_q;
  logic [WORD_W-1:0] hi_q;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] log_addr;

  always_comb begin
    case (state_q)
      SQ_ST_HI: off = old_slot(cls_q);
      SQ_ST_LO: off = old_slot(cls_q) + 12'h8;
      SQ_LD_HI: off = new_slot(cls_q);
      SQ_LD_LO: off = new_slot(cls_q) + 12'h8;
      default:  off = '0;
    endcase
  end

  assign log_addr = {{PFX_W{1'b0}}, off};

  psw_prefix_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .pfx_i (pfx_i),
    .log_i (log_addr),
    .phys_o(mem_addr_o)
  );

  assign mem_req_o   = (state_q != SQ_IDLE);
  assign mem_we_o    = (state_q == SQ_ST_HI) || (state_q == SQ_ST_LO);
  assign mem_wdata_o = (state_q == SQ_ST_HI) ? psw_i[PSW_W-1:WORD_W] : psw_i[WORD_W-1:0];
  assign busy_o      = mem_req_o;
  assign commit_o    = (state_q == SQ_LD_LO) && mem_ack_i;
  assign new_psw_o   = {hi_q, mem_rdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cls_q   <= CL_RESTART;
      hi_q    <= '0;
    end else begin
      case (state_q)
        SQ_IDLE:  if (start_i) begin
                    state_q <= SQ_ST_HI;
                    cls_q   <= cls_i;
                  end
        SQ_ST_HI: if (mem_ack_i) state_q <= SQ_ST_LO;
        SQ_ST_LO: if (mem_ack_i) state_q <= SQ_LD_HI;
        SQ_LD_HI: if (mem_ack_i) begin
                    state_q <= SQ_LD_LO;
                    hi_q    <= mem_rdata_i;
                  end
        SQ_LD_LO: if (mem_ack_i) state_q <= SQ_IDLE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psw_swap_unit.sv
module psw_swap_unit
  import psw_swap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [5:0]             irq_req_i,
  output logic [5:0]             irq_ack_o,
  input  logic                   psw_ld_i,
  input  logic [127:0]           psw_ld_data_i,
  input  logic                   amode64_set_i,
  input  logic                   pfx_we_i,
  input  logic [ADDR_W-13:0]     pfx_data_i,
  output logic [ADDR_W-13:0]     pfx_o,
  input  logic [ADDR_W-1:0]      xl_log_i,
  output logic [ADDR_W-1:0]      xl_phys_o,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [63:0]            mem_wdata_o,
  input  logic                   mem_ack_i,
  input  logic [63:0]            mem_rdata_i,
  output logic [127:0]           psw_o,
  output logic                   busy_o,
  output logic                   halted_o
);
  localparam int unsigned PFX_W = ADDR_W - OFF_W;

  logic [PSW_W-1:0] psw_q;
  logic [PFX_W-1:0] pfx_q;
  logic             grant_any;
  irq_class_e       grant_cls;
  logic             commit;
  logic [PSW_W-1:0] new_psw;

  assign halted_o = psw_q[B_WAIT] & ~psw_q[B_IO_MSK] & ~psw_q[B_EXT_MSK];

  psw_irq_arb u_arb (
    .req_i   (irq_req_i),
    .enable_i(!busy_o && !halted_o),
    .io_en_i (psw_q[B_IO_MSK]),
    .ext_en_i(psw_q[B_EXT_MSK]),
    .grant_o (irq_ack_o),
    .any_o   (grant_any),
    .cls_o   (grant_cls)
  );

  psw_swap_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (grant_any),
    .cls_i      (grant_cls),
    .psw_i      (psw_q),
    .pfx_i      (pfx_q),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .busy_o     (busy_o),
    .commit_o   (commit),
    .new_psw_o  (new_psw)
  );

  psw_prefix_xlate #(.ADDR_W(ADDR_W)) u_xl_port (
    .pfx_i (pfx_q),
    .log_i (xl_log_i),
    .phys_o(xl_phys_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q <= '0;
    end else if (commit) begin
      psw_q <= new_psw;
    end else if (!busy_o && !halted_o && !grant_any) begin
      if (psw_ld_i) begin
        psw_q <= psw_ld_data_i;
      end else if (amode64_set_i) begin
        psw_q[B_EA] <= 1'b1;
        psw_q[B_BA] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pfx_q <= '0;
    else if (pfx_we_i) pfx_q <= pfx_data_i;
  end

  assign pfx_o = pfx_q;
  assign psw_o = psw_q;

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_ack_o)); // R12
  AST_IO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o[CL_IO] |-> psw_o[B_IO_MSK]); // R4
  AST_EXT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o[CL_EXT] |-> psw_o[B_EXT_MSK]); // R4
  AST_PRIO_MCHK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i[CL_MCHK] && !busy_o && !halted_o) |-> irq_ack_o[CL_MCHK]); // R3
  AST_ACK_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_ack_o) |=> busy_o); // R12
  AST_PSW_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(psw_o)); // R6
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(psw_o))); // R11
  AST_SWAP_IN_PFX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[ADDR_W-1:OFF_W] == pfx_o)); // R9
endmodule

// File: tb/tb_psw_swap_unit.sv
module tb_psw_swap_unit;
  localparam int ADDR_W = 64;
  localparam logic [63:0] PFX_BASE = 64'h5000;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [5:0]    irq_req = '0;
  logic [5:0]    irq_ack;
  logic          psw_ld = 0;
  logic [127:0]  psw_ld_data = '0;
  logic          amode = 0;
  logic          pfx_we = 0;
  logic [51:0]   pfx_data = '0;
  logic [51:0]   pfx_rd;
  logic [63:0]   xl_log = '0;
  logic [63:0]   xl_phys;
  logic          mem_req, mem_we, mem_ack;
  logic [63:0]   mem_addr, mem_wdata, mem_rdata;
  logic [127:0]  psw;
  logic          busy, halted;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  psw_swap_unit #(.ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .irq_ack_o(irq_ack),
    .psw_ld_i(psw_ld), .psw_ld_data_i(psw_ld_data), .amode64_set_i(amode),
    .pfx_we_i(pfx_we), .pfx_data_i(pfx_data), .pfx_o(pfx_rd),
    .xl_log_i(xl_log), .xl_phys_o(xl_phys),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .psw_o(psw), .busy_o(busy), .halted_o(halted)
  );

  // memory model: acknowledge one cycle after a request
  logic [63:0] mem [logic [63:0]];
  function automatic logic [63:0] dflt(logic [63:0] a);
    return {8'h03, a[55:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : dflt(mem_addr);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] nslot(int c);
    case (c)
      0: return 12'h068;
      1: return 12'h1C0;
      2: return 12'h1C8;
      3: return 12'h1D0;
      4: return 12'h1D8;
      default: return 12'h1E0;
    endcase
  endfunction

  task automatic load_psw(input logic [127:0] v);
    @(negedge clk);
    psw_ld = 1; psw_ld_data = v;
    @(negedge clk);
    psw_ld = 0;
  endtask

  // vector table: control word, request lines, expected class (7 = none)
  localparam int NV = 9;
  localparam logic [63:0] V_HI [NV] = '{
    64'h0300_0000_0000_0000, 64'h0300_0000_0000_0000, 64'h0300_0000_0000_0000,
    64'h0300_0000_0000_0000, 64'h0300_0000_0000_0000, 64'h0300_0000_0000_0000,
    64'h0100_0000_0000_0000, 64'h0200_0000_0000_0000, 64'h0000_0000_0000_0000};
  localparam logic [5:0] V_REQ [NV] = '{
    6'b111111, 6'b101111, 6'b100111, 6'b100011, 6'b100001, 6'b000001,
    6'b100001, 6'b000011, 6'b100010};
  localparam int V_CLS [NV] = '{4, 3, 2, 1, 5, 0, 0, 0, 7};

  initial begin
    logic [127:0] ld, exp;
    logic [63:0]  base;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(psw == '0, "R1 psw reset", psw, '0);
    chk(busy == 0, "R1 busy reset", 128'(busy), 0);
    chk(halted == 0, "R1 halted reset", 128'(halted), 0);
    chk(pfx_rd == '0, "R1 prefix reset", 128'(pfx_rd), 0);

    @(negedge clk);
    pfx_we = 1; pfx_data = 52'h5;
    @(negedge clk);
    pfx_we = 0;
    chk(pfx_rd == 52'h5, "R8 prefix readback", 128'(pfx_rd), 128'h5);

    xl_log = 64'h0123; #1;
    chk(xl_phys == 64'h5123, "R9 page0 to prefix", 128'(xl_phys), 128'h5123);
    xl_log = 64'h5123; #1;
    chk(xl_phys == 64'h0123, "R9 prefix to page0", 128'(xl_phys), 128'h0123);
    xl_log = 64'h9123; #1;
    chk(xl_phys == 64'h9123, "R9 other unchanged", 128'(xl_phys), 128'h9123);

    for (int i = 0; i < NV; i++) begin
      ld = {V_HI[i], 64'h0000_C0DE_0000_0000 + 64'(i)};
      load_psw(ld);
      chk(psw == ld, "R2 psw load", psw, ld);
      irq_req = V_REQ[i];
      #1;
      exp = (V_CLS[i] == 7) ? 128'h0 : (128'h1 << V_CLS[i]);
      chk(irq_ack == exp[5:0], "R3 R4 R12 grant", 128'(irq_ack), exp);
      if (V_CLS[i] != 7) begin
        @(negedge clk);
        irq_req = '0;
        chk(busy && psw == ld, "R6 psw held during swap", psw, ld);
        n = 1;
        while (busy && n < 20) begin
          @(negedge clk);
          if (busy) chk(psw == ld, "R6 psw stable", psw, ld);
          n++;
        end
        n--;
        chk(n == 8, "R7 swap cycles", 128'(n), 128'd8);
        base = PFX_BASE + 64'(nslot(V_CLS[i]));
        exp = {dflt(base), dflt(base + 64'h8)};
        chk(psw == exp, "R5 new psw fetched", psw, exp);
        base = PFX_BASE + 64'h300 + 64'(16 * V_CLS[i]);
        chk(mem.exists(base) && mem[base] == ld[127:64], "R5 old control word saved",
            mem.exists(base) ? 128'(mem[base]) : 128'hX, 128'(ld[127:64]));
        chk(mem.exists(base + 8) && mem[base + 8] == ld[63:0], "R5 old address saved",
            mem.exists(base + 8) ? 128'(mem[base + 8]) : 128'hX, 128'(ld[63:0]));
      end else begin
        repeat (3) @(negedge clk);
        chk(!busy && psw == ld, "R4 masked request ignored", psw, ld);
        irq_req = '0;
      end
    end

    // R10 mode set
    load_psw({64'h0300_0000_8000_0000, 64'h1234});
    @(negedge clk);
    amode = 1;
    @(negedge clk);
    amode = 0;
    exp = {64'h0300_0001_0000_0000, 64'h1234};
    chk(psw == exp, "R10 64-bit mode set", psw, exp);

    // R11 disabled wait
    ld = {64'h2000_0000_0000_0000, 64'h99};
    load_psw(ld);
    chk(halted == 1, "R11 halt detected", 128'(halted), 1);
    irq_req = 6'b010000;
    #1;
    chk(irq_ack == 0, "R11 no grant when halted", 128'(irq_ack), 0);
    repeat (3) @(negedge clk);
    irq_req = '0;
    chk(!busy && psw == ld, "R11 request ignored", psw, ld);
    load_psw({64'h0300_0000_0000_0000, 64'h1});
    chk(psw == ld, "R11 load ignored", psw, ld);
    @(negedge clk); amode = 1;
    @(negedge clk); amode = 0;
    chk(psw == ld && halted, "R11 mode set ignored", psw, ld);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    #1;
    chk(!halted && psw == '0, "R11 reset leaves halt", psw, '0);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule